// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This unit turns a vector of general-purpose input pins into a small set of grouped interrupt requests. The input vector is assumed to be polarity-corrected already, so a logic one always means "active". Each pin can raise an interrupt in two ways. The level path uses the live input value. The edge path uses a sticky cause bit that is set on a 0-to-1 transition of the input and stays set until software clears it.

Every CPU has its own pair of enable vectors: one for edges and one for levels. A pin requests service when its input is high and level-enabled, or when its cause bit is set and edge-enabled. Requests are ORed in groups of `GRP` adjacent pins. The result is registered and drives one active-high line per group per CPU. A parameter selects whether the cause vector is shared by all CPUs or kept separately per CPU. Software handles both-edge sensing by flipping the upstream polarity.

Top module: `gpio_intc_unit`

## Requirements
- R1: After reset, every cause bit, edge enable, level enable and interrupt output is zero.
- R2: A cause bit sets on the clock edge at which its pin is 1 and was 0 at the previous edge. A falling input or a steady input leaves the cause bits unchanged.
- R3: A write to a cause slot clears each cause bit written as 0 and keeps each bit written as 1.
- R4: When a pin's rising edge and a write clearing that same bit occur in the same cycle, the bit ends up set.
- R5: A pin's level request is its input AND its level enable for that CPU. It follows the input, so it drops when the input returns to 0.
- R6: A pin's edge request is its cause bit AND its edge enable for that CPU. A cause bit whose edge enable is zero raises no interrupt, but it can still be read back.
- R7: Pin p drives output bit `cpu*NGRP + p/GRP`, and each output is the OR of the requests in its group.
- R8: The enables of one CPU affect only that CPU's outputs.
- R9: The register address is `{cpu, field}`, where the low 2 bits select the field: 0 is cause, 1 is edge enable, 2 is level enable, and 3 reads as zero and ignores writes. With a shared cause vector, the cause slot of every CPU reaches the same vector.
- R10: An input or enable change on the level path reaches the outputs one clock edge after it is sampled. An input rise reaches the outputs through the edge path two clock edges after it is sampled.
- R11: An input that is already high when reset is released does not set its cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Polarity-corrected pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address {cpu, field} |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Combinational read data for reg_addr |
| irq_o | output | NCPU*NGRP | Registered grouped interrupt lines, CPU-major |

## Verification
Level-path results and enable changes are due on the irq lines one clock edge after the input or write is sampled. An input rise is visible in the readable cause vector after one edge and on the irq lines after two. The bench drives inputs at the falling edge and advances one rising edge at a time. It samples just after the following falling edge. At the intermediate edge it confirms that an output has not appeared early. Cause reads are taken combinationally between edges, after the edge that updated the register.

// File: rtl/gpio_intc_pkg.sv
package gpio_intc_pkg;
   typedef enum logic [1:0] {
      FLD_CAUSE = 2'd0,
      FLD_EDGE  = 2'd1,
      FLD_LEVEL = 2'd2,
      FLD_RSVD  = 2'd3
   } fld_e;
endpackage

// File: rtl/gpio_cause_reg.sv
module gpio_cause_reg #(
   parameter int NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] rise,
   input  logic            clr_we,
   input  logic [NPIN-1:0] clr_keep,
   output logic [NPIN-1:0] cause
);
   logic [NPIN-1:0] keep_mask;

   always_comb keep_mask = clr_we ? clr_keep : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause <= '0;
      else        cause <= (cause & keep_mask) | rise;
   end

   // new edges always land, even against a clearing write
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));

   // bits appear only from a detected rise
   p_only_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & ~$past(cause) & ~$past(rise)) == '0));

   // without a write nothing is lost
   p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
   parameter int NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_edge,
   input  logic            we_level,
   input  logic [NPIN-1:0] wdata,
   output logic [NPIN-1:0] edge_en,
   output logic [NPIN-1:0] level_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_en  <= '0;
         level_en <= '0;
      end else begin
         if (we_edge)  edge_en  <= wdata;
         if (we_level) level_en <= wdata;
      end
   end

   p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_edge |=> $stable(edge_en));
   p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_level |=> $stable(level_en));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int NPIN = 32,
   parameter int GRP  = 8,
   localparam int NGRP = NPIN / GRP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] req,
   output logic [NGRP-1:0] irq
);
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq[g] <= 1'b0;
         else        irq[g] <= |req[g*GRP +: GRP];
      end
   end

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (irq == '0));
   p_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |=> (irq != '0));
endmodule

// File: rtl/gpio_intc_unit.sv
module gpio_intc_unit
   import gpio_intc_pkg::*;
#(
   parameter int NPIN          = 32,
   parameter int GRP           = 8,
   parameter int NCPU          = 2,
   parameter bit PER_CPU_CAUSE = 1'b0,
   localparam int NGRP   = NPIN / GRP,
   localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
   localparam int ADDR_W = CPU_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPIN-1:0]      pin_in,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [NPIN-1:0]      reg_wdata,
   output logic [NPIN-1:0]      reg_rdata,
   output logic [NCPU*NGRP-1:0] irq_o
);
   localparam int NCAUSE = PER_CPU_CAUSE ? NCPU : 1;

   if (NPIN % GRP != 0) begin : g_bad_grp
      $error("NPIN must be a multiple of GRP");
   end
   if (NCPU < 1 || NCPU > 4) begin : g_bad_cpu
      $error("NCPU must be 1 to 4");
   end

   fld_e             fld;
   logic [CPU_W-1:0] cpu_sel;
   logic [NPIN-1:0]  in_prev;
   logic             primed;
   logic [NPIN-1:0]  rise;
   logic [NPIN-1:0]  edge_en  [NCPU];
   logic [NPIN-1:0]  level_en [NCPU];
   logic [NPIN-1:0]  cause_q  [NCAUSE];
   logic [NPIN-1:0]  pin_req  [NCPU];

   always_comb begin
      fld     = fld_e'(reg_addr[1:0]);
      cpu_sel = reg_addr[ADDR_W-1:2];
   end

   // edge detector: primed blocks a false rise right after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_prev <= '0;
         primed  <= 1'b0;
      end else begin
         in_prev <= pin_in;
         primed  <= 1'b1;
      end
   end

   always_comb rise = primed ? (pin_in & ~in_prev) : '0;

   for (genvar k = 0; k < NCAUSE; k++) begin : g_cause
      logic clr_we;
      if (PER_CPU_CAUSE) begin : g_own
         always_comb clr_we = reg_we && fld == FLD_CAUSE && cpu_sel == CPU_W'(k);
      end else begin : g_shared
         always_comb clr_we = reg_we && fld == FLD_CAUSE && int'(cpu_sel) < NCPU;
      end
      gpio_cause_reg #(.NPIN(NPIN)) u_cause (
         .clk(clk), .rst_n(rst_n), .rise(rise),
         .clr_we(clr_we), .clr_keep(reg_wdata), .cause(cause_q[k])
      );
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic we_e, we_l;
      always_comb begin
         we_e = reg_we && fld == FLD_EDGE  && cpu_sel == CPU_W'(c);
         we_l = reg_we && fld == FLD_LEVEL && cpu_sel == CPU_W'(c);
      end
      gpio_mask_bank #(.NPIN(NPIN)) u_bank (
         .clk(clk), .rst_n(rst_n), .we_edge(we_e), .we_level(we_l),
         .wdata(reg_wdata), .edge_en(edge_en[c]), .level_en(level_en[c])
      );
      always_comb pin_req[c] = (pin_in & level_en[c]) | (cause_q[c % NCAUSE] & edge_en[c]);
      gpio_irq_group #(.NPIN(NPIN), .GRP(GRP)) u_grp (
         .clk(clk), .rst_n(rst_n), .req(pin_req[c]),
         .irq(irq_o[c*NGRP +: NGRP])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCPU; c++) begin
         if (cpu_sel == CPU_W'(c)) begin
            case (fld)
               FLD_CAUSE: reg_rdata = cause_q[c % NCAUSE];
               FLD_EDGE:  reg_rdata = edge_en[c];
               FLD_LEVEL: reg_rdata = level_en[c];
               default:   reg_rdata = '0;
            endcase
         end
      end
   end

   logic any_en;
   always_comb begin
      any_en = 1'b0;
      for (int c = 0; c < NCPU; c++) any_en = any_en | (|edge_en[c]) | (|level_en[c]);
   end

   // with every enable cleared no line may rise
   p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !any_en |=> (irq_o == '0));

   // reserved field always reads zero
   p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fld == FLD_RSVD) |-> (reg_rdata == '0));
endmodule

// File: tb/gpio_intc_unit_tb.sv
module gpio_intc_unit_tb;
   localparam int NPIN = 32;
   localparam int GRP  = 8;
   localparam int NCPU = 2;
   localparam int NGRP = NPIN / GRP;
   localparam int AW   = 3;
   localparam int NIRQ = NCPU * NGRP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] pin_in = '0;
   logic            reg_we = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [NPIN-1:0] reg_wdata = '0;
   logic [NPIN-1:0] reg_rdata;
   logic [NIRQ-1:0] irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gpio_intc_unit #(.NPIN(NPIN), .GRP(GRP), .NCPU(NCPU), .PER_CPU_CAUSE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_we = 1'b0; reg_addr = AW'(a);
      #0.5;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      pin_in = '1;                      // high through reset for R11
      repeat (3) @(negedge clk);
      check("R1 irq", 32'(irq_o), 32'h0);
      rst_n = 1'b1;
      tick(); tick();
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         check("R1 R11 regs after reset", v, 32'h0);
      end
      check("R1 irq after release", 32'(irq_o), 32'h0);
      pin_in = '0;
      tick();
      rd(0, v);
      check("R2 falling sets nothing", v, 32'h0);

      // level path sweep: R5 R7 R8 R10
      for (int c = 0; c < NCPU; c++) begin
         for (int p = 0; p < NPIN; p++) begin
            wr(c*4 + 2, 32'h1 << p);
            pin_in = 32'h1 << p;
            check("R10 level not early", 32'(irq_o), 32'h0);
            tick();
            check("R5 R7 R8 level grouped", 32'(irq_o), 32'h1 << (c*NGRP + p/GRP));
            pin_in = '0;
            tick();
            check("R5 level follows input", 32'(irq_o), 32'h0);
         end
         wr(c*4 + 2, 32'h0);
         rd(0, v);
         wr(0, 32'h0);
      end

      // edge capture sweep, masked: R2 R3 R6
      for (int p = 0; p < NPIN; p++) begin
         pin_in = 32'h1 << p;
         tick();
         rd(0, v);
         check("R2 rise sets cause", v, 32'h1 << p);
         check("R6 masked cause no irq", 32'(irq_o), 32'h0);
         pin_in = '0;
         tick();
         rd(0, v);
         check("R2 fall keeps cause", v, 32'h1 << p);
         wr(0, ~(32'h1 << p));
         rd(0, v);
         check("R3 ack one pin", v, 32'h0);
      end

      // edge path through enable: R6 R10 R8 R9 alias
      wr(1, 32'hFFFF_FFFF);
      pin_in = 32'h1 << 5;
      tick();
      check("R10 edge not after one edge", 32'(irq_o), 32'h0);
      tick();
      check("R6 R8 edge irq cpu0 only", 32'(irq_o), 32'h1);
      wr(4, ~(32'h1 << 5));
      rd(0, v);
      check("R9 cause alias cleared via cpu1 slot", v, 32'h0);
      tick();
      check("R6 irq drops after ack", 32'(irq_o), 32'h0);
      wr(1, 32'h0);
      pin_in = '0;
      tick();

      // partial clear: R3
      pin_in = 32'h0000_0F0F;
      tick();
      pin_in = '0;
      wr(0, 32'hFFFF_00FF);
      rd(0, v);
      check("R3 partial clear", v, 32'h0000_000F);
      wr(0, 32'h0);

      // set beats clear: R4
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
      pin_in = 32'h8;
      tick();
      reg_we = 1'b0;
      rd(0, v);
      check("R4 set wins", v, 32'h8);
      pin_in = '0;
      wr(0, 32'h0);

      // reserved slots and decode: R9
      wr(5, 32'h1234_5678);
      wr(3, 32'hFFFF_FFFF);
      wr(7, 32'hFFFF_FFFF);
      rd(3, v); check("R9 rsvd cpu0 reads zero", v, 32'h0);
      rd(7, v); check("R9 rsvd cpu1 reads zero", v, 32'h0);
      rd(5, v); check("R9 cpu1 edge enable", v, 32'h1234_5678);
      rd(1, v); check("R9 cpu0 edge untouched", v, 32'h0);
      rd(2, v); check("R9 cpu0 level untouched", v, 32'h0);
      rd(6, v); check("R9 cpu1 level untouched", v, 32'h0);

      finish_run();
   end
endmodule